// File: doc/BRIEF.md
# Wiegand Two-Wire Frame Receiver

This block takes the two data lines of an access-control card reader and turns their pulse stream into frames of bits. One line carries the zeros and the other carries the ones. Each line first passes through a two-flop synchroniser. A configuration pin then selects whether the active level is low or high. A new bit is taken only when the pair of line levels changes into a pattern with exactly one line active.

A free-running prescaler divides the system clock into sample ticks. A per-frame timer counts these ticks from the most recent bit, and the bit-period select pins set its limit. When the timer expires with both lines quiet, the frame is closed. When it expires with either line still active, the line is treated as stuck.

The receiver keeps a three-state machine with the states idle, data and invalid. A line clash or a stuck line moves it to invalid. It stays there until both lines are seen inactive together, so swapped or inverted wiring is never read as data. Whenever the machine leaves the data state, it reports the received bits, the bit count and an overflow flag, together with a one-cycle done strobe.

Top module: `wgd_rx`

## Requirements
- R1: A change of the line pair into "zero line active, one line inactive" appends a 0. A change into "one line active, zero line inactive" appends a 1. Each new bit enters at bit 0 of the frame register, so after n bits (n up to 64) the first bit received sits at bit n-1.
- R2: `cfg_active_high` = 0 makes a low level active on both lines, and 1 makes a high level active. This pin is read during reset and while running.
- R3: `cfg_period_sel` codes 0,1,2,3,4,5 select a bit period of 1,2,4,8,16,32 ms, and codes 6 and 7 also select 32 ms. The limit in ticks is floor(period_us / TICK_US), raised to 1 when it would be 0. One tick occurs every CLKS_PER_TICK clocks.
- R4: A bit is taken only on a change of the synchronised line pair. Holding a one-line-active level for any length of time within the period adds no further bits.
- R5: A change to both lines active while idle or receiving moves the machine to invalid and raises `error_o` for one cycle.
- R6: In the invalid state every line pattern except both-inactive is ignored, and no bit, strobe or report is produced. A change to both-inactive returns the machine to idle.
- R7: Each bit restarts the timer. If the limit is reached and the line pair has not changed in that cycle, and both lines are inactive, the frame ends and the machine goes idle.
- R8: If the timer expires while either line is still active, the machine enters invalid and raises `error_o`. When it was receiving, the frame is also reported in the same cycle.
- R9: Leaving the data state for any reason pulses `frame_done_o` for one cycle. In the same cycle, `bit_count_o` and `frame_bits_o` take the frame's bit count and bits.
- R10: A frame keeps its first 64 bits. Later bits are neither shifted in nor counted, and they set `frame_ovf_o` in the report. A frame without excess bits reports `frame_ovf_o` = 0.
- R11: After reset all outputs are 0 and the machine is idle. The report outputs change only in a cycle where `frame_done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_active_high | input | 1 | 1: lines active high; 0: active low |
| cfg_period_sel | input | 3 | Bit period select code |
| d0_i | input | 1 | Zero-bit data line (asynchronous) |
| d1_i | input | 1 | One-bit data line (asynchronous) |
| frame_bits_o | output | FRAME_W | Bits of the last frame, most recent at bit 0 |
| bit_count_o | output | $clog2(FRAME_W+1) | Bit count of the last frame |
| frame_ovf_o | output | 1 | Last frame exceeded FRAME_W bits |
| frame_done_o | output | 1 | One-cycle strobe: frame reported |
| error_o | output | 1 | One-cycle strobe: entered invalid |

## Verification
The frame report and the error strobe can occur in the same cycle. This happens when a frame in progress ends by a line clash or by a stuck line. The bench provokes both cases. It drives both lines active after three bits, and it holds the zero line active past the bit period after a one bit. In each case the bench expects `frame_done_o` and `error_o` together on one clock edge, with the report carrying only the bits taken before the fault. A clash from idle is also driven, and it must give the error strobe alone.

// File: rtl/wgd_pkg.sv
package wgd_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DATA = 2'd1,
    S_INV  = 2'd2
  } wgd_state_e;

  // Bit period in microseconds for a select code; codes above 5 clamp to 32 ms.
  function automatic int unsigned period_us(input logic [2:0] sel);
    int unsigned ms;
    ms = (sel > 3'd5) ? 32'd32 : (32'd1 << sel);
    return ms * 32'd1000;
  endfunction

  // Timeout limit in ticks: truncated quotient, floored at one tick.
  function automatic int unsigned period_ticks(input logic [2:0] sel,
                                               input int unsigned tick_us);
    int unsigned t;
    t = period_us(sel) / tick_us;
    return (t == 0) ? 32'd1 : t;
  endfunction

endpackage

// File: rtl/wgd_sync.sv
module wgd_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_high,
  input  logic [LANES-1:0] raw_i,
  output logic [LANES-1:0] act_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= {STAGES{~active_high}};
      else        sh <= {sh[STAGES-2:0], raw_i[g]};
    end
    // Convert to active-true after the last stage.
    assign act_o[g] = sh[STAGES-1] ^ ~active_high;
  end

endmodule

// File: rtl/wgd_tick.sv
module wgd_tick #(
  parameter int DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && DIV > 1) |=> !tick_o);

endmodule

// File: rtl/wgd_timer.sv
module wgd_timer
  import wgd_pkg::*;
#(
  parameter int unsigned TICK_US = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       expired_o
);

  localparam int unsigned MAXT = period_ticks(3'd5, TICK_US);
  localparam int          TW   = $clog2(MAXT + 1);

  logic [TW-1:0] lim;
  logic [TW-1:0] tcnt_q;
  logic          armed_q;

  always_comb lim = TW'(period_ticks(sel_i, TICK_US));

  assign expired_o = armed_q && (tcnt_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tcnt_q  <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      tcnt_q  <= '0;
    end else if (stop_i) begin
      armed_q <= 1'b0;
      tcnt_q  <= '0;
    end else if (tick_i && armed_q && tcnt_q < lim) begin
      tcnt_q  <= tcnt_q + TW'(1);
    end
  end

  // R7: every bit restarts the count from zero
  p_timer_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (armed_q && tcnt_q == '0));

  p_timer_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !expired_o);

endmodule

// File: rtl/wgd_rx.sv
module wgd_rx
  import wgd_pkg::*;
#(
  parameter int          CLKS_PER_TICK = 100000,
  parameter int unsigned TICK_US       = 1000,
  parameter int          FRAME_W       = 64,
  localparam int         CNT_W         = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_active_high,
  input  logic [2:0]         cfg_period_sel,
  input  logic               d0_i,
  input  logic               d1_i,
  output logic [FRAME_W-1:0] frame_bits_o,
  output logic [CNT_W-1:0]   bit_count_o,
  output logic               frame_ovf_o,
  output logic               frame_done_o,
  output logic               error_o
);

  function automatic logic [FRAME_W-1:0] push_bit(input logic [FRAME_W-1:0] cur,
                                                  input logic b);
    return {cur[FRAME_W-2:0], b};
  endfunction

  function automatic logic room_left(input logic [CNT_W-1:0] n);
    return n < CNT_W'(FRAME_W);
  endfunction

  // Synchronised, polarity-corrected lines: act[0] zero line, act[1] one line.
  logic [1:0] act;
  logic [1:0] prev_q;
  logic       tick;
  logic       expired;

  wgd_sync #(.LANES(2), .STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_high(cfg_active_high),
    .raw_i      ({d1_i, d0_i}),
    .act_o      (act)
  );

  wgd_tick #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(tick)
  );

  // Named events
  wgd_state_e state_q, state_d;
  logic pair_chg, live, pat_none, pat_zero, pat_one, pat_both;
  logic bit_evt, bit_val, clash_evt, clear_evt, tmo_evt, quiet_end, stuck_evt;
  logic enter_inv, report_evt, timer_stop;

  assign pair_chg   = (act != prev_q);
  assign live       = (state_q != S_INV);
  assign pat_none   = (act == 2'b00);
  assign pat_zero   = (act == 2'b01);
  assign pat_one    = (act == 2'b10);
  assign pat_both   = (act == 2'b11);
  assign bit_evt    = pair_chg && live && (pat_zero || pat_one);
  assign bit_val    = pat_one;
  assign clash_evt  = pair_chg && live && pat_both;
  assign clear_evt  = pair_chg && !live && pat_none;
  assign tmo_evt    = !pair_chg && expired;
  assign quiet_end  = tmo_evt && pat_none;
  assign stuck_evt  = tmo_evt && !pat_none;
  assign enter_inv  = clash_evt || stuck_evt;
  assign report_evt = (state_q == S_DATA) && (enter_inv || quiet_end);
  assign timer_stop = enter_inv || quiet_end || clear_evt;

  wgd_timer #(.TICK_US(TICK_US)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (cfg_period_sel),
    .tick_i   (tick),
    .start_i  (bit_evt),
    .stop_i   (timer_stop),
    .expired_o(expired)
  );

  always_comb begin
    state_d = state_q;
    if (bit_evt)                     state_d = S_DATA;
    else if (enter_inv)              state_d = S_INV;
    else if (quiet_end || clear_evt) state_d = S_IDLE;
  end

  // Frame accumulator
  logic [FRAME_W-1:0] acc_q;
  logic [CNT_W-1:0]   acc_cnt_q;
  logic               acc_ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      prev_q       <= 2'b00;
      acc_q        <= '0;
      acc_cnt_q    <= '0;
      acc_ovf_q    <= 1'b0;
      frame_bits_o <= '0;
      bit_count_o  <= '0;
      frame_ovf_o  <= 1'b0;
      frame_done_o <= 1'b0;
      error_o      <= 1'b0;
    end else begin
      state_q      <= state_d;
      prev_q       <= act;
      frame_done_o <= report_evt;
      error_o      <= enter_inv;
      if (bit_evt) begin
        if (state_q != S_DATA) begin
          acc_q     <= FRAME_W'(bit_val);
          acc_cnt_q <= CNT_W'(1);
          acc_ovf_q <= 1'b0;
        end else if (room_left(acc_cnt_q)) begin
          acc_q     <= push_bit(acc_q, bit_val);
          acc_cnt_q <= acc_cnt_q + CNT_W'(1);
        end else begin
          acc_ovf_q <= 1'b1;
        end
      end
      if (report_evt) begin
        frame_bits_o <= acc_q;
        bit_count_o  <= acc_cnt_q;
        frame_ovf_o  <= acc_ovf_q;
      end
    end
  end

  // Assertions
  p_held_no_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_chg && state_q == S_DATA) |=> $stable(acc_cnt_q));

  p_err_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (state_q == S_INV));

  p_inv_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_INV && !pat_none) |=> (state_q == S_INV && !frame_done_o));

  p_inv_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_INV && pat_none && prev_q != 2'b00) |=> (state_q == S_IDLE));

  p_done_left_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (state_q != S_DATA));

  p_done_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  p_count_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count_o <= CNT_W'(FRAME_W));

  p_report_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done_o |-> ($stable(bit_count_o) && $stable(frame_bits_o) && $stable(frame_ovf_o)));

endmodule

// File: tb/sim_wgd_rx.sv
module sim_wgd_rx;

  localparam int CLKS = 4;
  localparam int TUS  = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_active_high = 1'b0;
  logic [2:0]  cfg_period_sel = 3'd5;
  logic        d0_i = 1'b1;
  logic        d1_i = 1'b1;
  logic [63:0] frame_bits_o;
  logic [6:0]  bit_count_o;
  logic        frame_ovf_o, frame_done_o, error_o;

  always #5 clk = ~clk;

  wgd_rx #(.CLKS_PER_TICK(CLKS), .TICK_US(TUS), .FRAME_W(64)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_active_high(cfg_active_high),
    .cfg_period_sel(cfg_period_sel), .d0_i(d0_i), .d1_i(d1_i),
    .frame_bits_o(frame_bits_o), .bit_count_o(bit_count_o),
    .frame_ovf_o(frame_ovf_o), .frame_done_o(frame_done_o), .error_o(error_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  function automatic int limit_ticks(input logic [2:0] sel);
    int ms;
    int t;
    ms = 32;
    if (sel < 3'd6) ms = 2 ** int'(sel);
    t = (ms * 1000) / TUS;
    if (t < 1) t = 1;
    return t;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act_v, input logic [63:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act_v, exp_v);
    end
  endtask

  // Behavioural reference: pipeline of line history, mode, frame list.
  int          m_st;          // 0 idle, 1 data, 2 invalid
  logic [1:0]  m_hist [3];    // [0] newest sample, [1] seen by decision, [2] previous decision pair
  int          m_elapsed;
  bit          m_armed;
  int          m_phase;
  logic [63:0] m_acc;
  int          m_cnt;
  bit          m_ovf;
  logic [63:0] e_bits;
  int          e_cnt;
  bit          e_ovf, e_done, e_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_elapsed = 0; m_armed = 0; m_phase = 0;
      foreach (m_hist[i]) m_hist[i] = 2'b00;
      m_acc = '0; m_cnt = 0; m_ovf = 0;
      e_bits = '0; e_cnt = 0; e_ovf = 0; e_done = 0; e_err = 0;
    end else begin
      logic [1:0] a;
      int bitv;
      int leave;
      a = m_hist[1];
      bitv = -1; leave = 0; e_done = 0; e_err = 0;
      if (a != m_hist[2]) begin
        if (m_st != 2) begin
          if (a == 2'b01) bitv = 0;
          else if (a == 2'b10) bitv = 1;
          else if (a == 2'b11) leave = 2;
        end else if (a == 2'b00) leave = 1;
      end else if (m_armed && m_elapsed >= limit_ticks(cfg_period_sel)) begin
        leave = (a == 2'b00) ? 1 : 2;
      end
      if (bitv >= 0) begin
        if (m_st != 1) begin m_acc = 64'(bitv); m_cnt = 1; m_ovf = 0; end
        else if (m_cnt < 64) begin m_acc = {m_acc[62:0], bitv[0]}; m_cnt++; end
        else m_ovf = 1;
        m_st = 1; m_armed = 1; m_elapsed = 0;
      end else if (leave != 0) begin
        if (m_st == 1) begin e_done = 1; e_bits = m_acc; e_cnt = m_cnt; e_ovf = m_ovf; end
        e_err = (leave == 2);
        m_st = (leave == 2) ? 2 : 0;
        m_armed = 0; m_elapsed = 0;
      end else if (m_phase == CLKS - 1 && m_armed && m_elapsed < limit_ticks(cfg_period_sel)) begin
        m_elapsed++;
      end
      m_phase = (m_phase == CLKS - 1) ? 0 : m_phase + 1;
      m_hist[2] = a;
      m_hist[1] = m_hist[0];
      m_hist[0] = {d1_i == cfg_active_high, d0_i == cfg_active_high};
    end
  end

  // Per-cycle comparison and strobe counters
  int n_done = 0, n_err = 0, n_both = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      checks += 2;
      if (error_o !== e_err) begin
        errors++;
        $display("FAIL R5 cycle compare error_o: actual %0b expected %0b", error_o, e_err);
      end
      if (frame_done_o !== e_done || int'(bit_count_o) != e_cnt ||
          frame_bits_o !== e_bits || frame_ovf_o !== e_ovf) begin
        errors++;
        $display("FAIL R9 cycle compare done/cnt/ovf/bits: actual %0b/%0d/%0b/%0h expected %0b/%0d/%0b/%0h",
                 frame_done_o, bit_count_o, frame_ovf_o, frame_bits_o, e_done, e_cnt, e_ovf, e_bits);
      end
      if (frame_done_o) n_done++;
      if (error_o) n_err++;
      if (frame_done_o && error_o) n_both++;
    end
  end

  task automatic set_lines(input bit z, input bit o);
    d0_i = z ? cfg_active_high : ~cfg_active_high;
    d1_i = o ? cfg_active_high : ~cfg_active_high;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk);
    set_lines(!b, b);
    repeat (2) @(negedge clk);
    set_lines(0, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_done(output int cyc);
    int start;
    start = n_done;
    cyc = 0;
    while (n_done == start && cyc < 400) begin
      @(negedge clk); #1; cyc++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    set_lines(0, 0);
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  initial begin
    int cyc;
    int d0, e0;
    logic [63:0] ov_exp;
    do_reset();
    // R11 reset state
    chk("R11 reset bit_count", 64'(bit_count_o), 64'd0);
    chk("R11 reset strobes", {62'd0, frame_done_o, error_o}, 64'd0);

    // R1 / R9: plain frame 1,0,1,1,0
    send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
    wait_done(cyc);
    chk("R9 frame count", 64'(bit_count_o), 64'd5);
    chk("R1 frame bits first-bit-high", frame_bits_o, 64'b10110);
    d0 = n_done;
    step(20);
    chk("R11 report holds", {57'd0, bit_count_o}, 64'd5);
    chk("R11 no extra strobe", 64'(n_done - d0), 64'd0);

    // R4: held zero level then a one pulse
    @(negedge clk); set_lines(1, 0); step(20); set_lines(0, 0); step(6);
    send_bit(1);
    wait_done(cyc);
    chk("R4 held level single bit count", 64'(bit_count_o), 64'd2);
    chk("R4 held level bits", frame_bits_o, 64'b01);

    // R5 clash during data, then R6 sticky invalid
    e0 = n_both;
    send_bit(1); send_bit(1); send_bit(0);
    @(negedge clk); set_lines(1, 1);
    wait_done(cyc);
    step(1);
    chk("R5 clash report and error same cycle", 64'(n_both - e0), 64'd1);
    chk("R5 clash frame count", 64'(bit_count_o), 64'd3);
    d0 = n_done; e0 = n_err;
    set_lines(1, 0); step(8);
    set_lines(0, 1); step(8);
    set_lines(1, 1); step(8);
    set_lines(0, 1); step(60);
    chk("R6 invalid ignores activity (done)", 64'(n_done - d0), 64'd0);
    chk("R6 invalid ignores activity (error)", 64'(n_err - e0), 64'd0);
    set_lines(0, 0); step(6);
    send_bit(1);
    wait_done(cyc);
    chk("R6 recovery frame count", 64'(bit_count_o), 64'd1);
    chk("R6 recovery frame bits", frame_bits_o, 64'd1);

    // R5 clash from idle: error alone
    d0 = n_done; e0 = n_err;
    @(negedge clk); set_lines(1, 1); step(8); set_lines(0, 0); step(8);
    chk("R5 idle clash error", 64'(n_err - e0), 64'd1);
    chk("R5 idle clash no report", 64'(n_done - d0), 64'd0);

    // R8 stuck line after one bit
    e0 = n_both;
    send_bit(1);
    @(negedge clk); set_lines(1, 0);
    wait_done(cyc);
    step(1);
    chk("R8 stuck gives report with error", 64'(n_both - e0), 64'd1);
    chk("R8 stuck frame bits", frame_bits_o, 64'b10);
    set_lines(0, 0); step(10);

    // R3 / R7 timeout windows
    foreach (d0_sel_list[k]) begin
      int n;
      cfg_period_sel = d0_sel_list[k];
      n = limit_ticks(d0_sel_list[k]);
      e0 = n_err;
      @(negedge clk); set_lines(1, 0); @(negedge clk); set_lines(0, 0);
      wait_done(cyc);
      checks++;
      if (cyc < CLKS * (n - 1) || cyc > CLKS * n + 8) begin
        errors++;
        $display("FAIL R3 timeout sel %0d: actual %0d cycles expected %0d..%0d",
                 d0_sel_list[k], cyc, CLKS * (n - 1), CLKS * n + 8);
      end
      chk("R7 quiet timeout no error", 64'(n_err - e0), 64'd0);
      step(4);
    end
    cfg_period_sel = 3'd5;

    // R10 overflow
    ov_exp = '0;
    for (int i = 0; i < 66; i++) begin
      if (i < 64) ov_exp = {ov_exp[62:0], (i % 3 == 0)};
      send_bit(i % 3 == 0);
    end
    wait_done(cyc);
    chk("R10 overflow count", 64'(bit_count_o), 64'd64);
    chk("R10 overflow bits", frame_bits_o, ov_exp);
    chk("R10 overflow flag", 64'(frame_ovf_o), 64'd1);
    send_bit(0);
    wait_done(cyc);
    chk("R10 flag clears", 64'(frame_ovf_o), 64'd0);

    // R2 active-high lines
    cfg_active_high = 1'b1;
    do_reset();
    send_bit(0); send_bit(1); send_bit(1);
    wait_done(cyc);
    chk("R2 active high count", 64'(bit_count_o), 64'd3);
    chk("R2 active high bits", frame_bits_o, 64'b011);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [2:0] d0_sel_list [3] = '{3'd0, 3'd4, 3'd7};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule